// File: doc/BRIEF.md
# Channel Service Scheduler

This block decides which of N channels an execution engine serves next. The engine runs one thread at a time. Each channel carries a 2-bit priority field written by the host. The field selects one of three active levels or switches the channel off. Request pulses from the channels are held in a pending register until the channel is started. When the engine is idle, or one clock after it reports the end of a thread, the scheduler picks one eligible channel. It then presents that channel's index together with a one-cycle start strobe.

Fairness inside a level comes from one sticky grant bit per channel. Serving a channel sets its bit, and a channel whose bit is set is passed over. The bits of a level are cleared together once every channel at that level that still has a request pending already holds its bit. The bits of switched-off channels are cleared whenever this clearing step runs. A channel that is switched off keeps its pending requests and is served once it is enabled again. Switching off a channel whose thread is running does not stop that thread. The block has no abort path, and the engine finishes the thread.

Top module: `svc_sched`

## Requirements
- R1: After reset, start_o is low, chan_o is 0 and every channel is disabled. No channel is started until its priority field becomes non-zero, even if requests arrive.
- R2: The priority field of channel c is prio_i[2c+1:2c]. The codes are 0 = disabled, 1 = low, 2 = middle and 3 = high. A channel is eligible when it has a pending request, its grant bit is clear and its code is non-zero. Among eligible channels, the one at the highest code is selected.
- R3: When several eligible channels share the highest code, the one with the lowest channel number is selected.
- R4: Starting a channel sets its grant bit. A channel whose grant bit is set is not started again, even with a new request pending, until that bit has been cleared.
- R5: In the clearing step, all grant bits of an active level are cleared when every channel at that level with a pending request already has its grant bit set. The grant bits of disabled channels are always cleared. The clearing step runs in every clock in which thread_end_i is high or a selection is allowed, and the selection in that clock uses the cleared bits.
- R6: A request that was pending when its channel was disabled, or that arrives while the channel is disabled, stays pending. It is served after the channel is enabled again.
- R7: Starting a channel removes its pending request. A request on that channel in the same clock as the selection remains pending and leads to a later start.
- R8: A selection is allowed in a clock where idle_i is high or thread_end_i was high in the previous clock, unless start_o is high in that clock. start_o is high for exactly the clock after a selection, with chan_o giving the selected channel. chan_o holds its value between starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prio_i | input | 2*NCH | Per-channel priority codes, 2 bits per channel |
| req_i | input | NCH | Per-channel service request pulses |
| thread_end_i | input | 1 | Engine reports the end of the running thread |
| idle_i | input | 1 | Engine has no thread running |
| start_o | output | 1 | One-cycle strobe: start a thread for chan_o |
| chan_o | output | IDXW | Index of the channel being started |

## Verification
Two functions can fall in the same clock. A channel's pending request is removed when the channel is started, and a fresh request can arrive for that same channel in that clock. One directed case drives a second request for a channel exactly in the clock where it is selected. The channel must then be started a second time once the grant bits of its level have been cleared. Random traffic with sparse requests and changing priorities produces the same collision by chance. Every clock is compared against a reference model that the bench builds from the requirements.

// File: rtl/sched_pkg.sv
package sched_pkg;
  typedef enum logic [1:0] {
    LV_OFF  = 2'd0,
    LV_LOW  = 2'd1,
    LV_MID  = 2'd2,
    LV_HIGH = 2'd3
  } lvl_e;

  localparam int unsigned NUM_LVL = 4;
  localparam int unsigned LVL_W   = 2;
endpackage

// File: rtl/sched_req_latch.sv
module sched_req_latch #(
  parameter int unsigned NCH  = 32,
  parameter int unsigned IDXW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH-1:0]  req_i,
  input  logic            take_i,
  input  logic [IDXW-1:0] take_idx_i,
  output logic [NCH-1:0]  pend_o
);
  logic [NCH-1:0] pend_q;
  logic [NCH-1:0] pend_d;
  logic [NCH-1:0] take_mask;

  always_comb begin
    take_mask = '0;
    if (take_i) take_mask = NCH'(1) << take_idx_i;
    // a fresh request wins over the clear of the started channel
    pend_d = (pend_q & ~take_mask) | req_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  // R6 R7
  req_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_i) |=> (|pend_q));
endmodule

// File: rtl/sched_grant_track.sv
module sched_grant_track
  import sched_pkg::*;
#(
  parameter int unsigned NCH  = 32,
  parameter int unsigned IDXW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LVL_W*NCH-1:0] prio_i,
  input  logic [NCH-1:0]     pend_i,
  input  logic               clr_en_i,
  input  logic               set_i,
  input  logic [IDXW-1:0]    set_idx_i,
  output logic [NCH-1:0]     grant_eff_o,
  output logic [NCH-1:0]     grant_o
);
  logic [NCH-1:0]     grant_q;
  logic [NCH-1:0]     grant_d;
  logic [NCH-1:0]     grant_clr;
  logic [NUM_LVL-1:0] lvl_done;

  // disabled level is always released by the clearing step
  assign lvl_done[0] = 1'b1;

  for (genvar lv = 1; lv < NUM_LVL; lv++) begin : g_lvl
    always_comb begin
      lvl_done[lv] = 1'b1;
      for (int c = 0; c < NCH; c++) begin
        if (prio_i[LVL_W*c +: LVL_W] == LVL_W'(lv) && pend_i[c] && !grant_q[c])
          lvl_done[lv] = 1'b0;
      end
    end
  end

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      grant_clr[c] = (clr_en_i && lvl_done[prio_i[LVL_W*c +: LVL_W]]) ? 1'b0 : grant_q[c];
    end
    grant_d = grant_clr;
    if (set_i) grant_d = grant_clr | (NCH'(1) << set_idx_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) grant_q <= '0;
    else        grant_q <= grant_d;
  end

  assign grant_eff_o = grant_clr;
  assign grant_o     = grant_q;
endmodule

// File: rtl/sched_pick_arb.sv
module sched_pick_arb
  import sched_pkg::*;
#(
  parameter int unsigned NCH  = 32,
  parameter int unsigned IDXW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [LVL_W*NCH-1:0] prio_i,
  input  logic [NCH-1:0]       pend_i,
  input  logic [NCH-1:0]       grant_i,
  output logic                 pick_vld_o,
  output logic [IDXW-1:0]      pick_idx_o
);
  logic [NCH-1:0]     elig [NUM_LVL];
  logic [NUM_LVL-1:0] lvl_any;
  logic [NCH-1:0]     win_vec;

  assign elig[0]    = '0;
  assign lvl_any[0] = 1'b0;

  for (genvar lv = 1; lv < NUM_LVL; lv++) begin : g_lvl
    always_comb begin
      for (int c = 0; c < NCH; c++) begin
        elig[lv][c] = pend_i[c] && !grant_i[c] &&
                      (prio_i[LVL_W*c +: LVL_W] == LVL_W'(lv));
      end
    end
    assign lvl_any[lv] = |elig[lv];
  end

  // highest active level with an eligible channel
  always_comb begin
    win_vec = '0;
    for (int lv = 1; lv < NUM_LVL; lv++) begin
      if (lvl_any[lv]) win_vec = elig[lv];
    end
  end

  // lowest channel number inside the winning level
  always_comb begin
    pick_idx_o = '0;
    for (int c = NCH - 1; c >= 0; c--) begin
      if (win_vec[c]) pick_idx_o = IDXW'(c);
    end
  end

  assign pick_vld_o = |win_vec;
endmodule

// File: rtl/svc_sched.sv
module svc_sched
  import sched_pkg::*;
#(
  parameter int unsigned NCH  = 32,
  parameter int unsigned IDXW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [LVL_W*NCH-1:0] prio_i,
  input  logic [NCH-1:0]       req_i,
  input  logic                 thread_end_i,
  input  logic                 idle_i,
  output logic                 start_o,
  output logic [IDXW-1:0]      chan_o
);
  logic            start_q;
  logic [IDXW-1:0] chan_q;
  logic            end_q;
  logic            sel_ok;
  logic            clr_en;
  logic            take;
  logic            pick_vld;
  logic [IDXW-1:0] pick_idx;
  logic [NCH-1:0]  pend;
  logic [NCH-1:0]  grant_eff;
  logic [NCH-1:0]  grant_q;

  assign sel_ok = !start_q && (idle_i || end_q);
  assign clr_en = thread_end_i || sel_ok;
  assign take   = sel_ok && pick_vld;

  sched_req_latch #(.NCH(NCH), .IDXW(IDXW)) i_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req_i),
    .take_i     (take),
    .take_idx_i (pick_idx),
    .pend_o     (pend)
  );

  sched_grant_track #(.NCH(NCH), .IDXW(IDXW)) i_grant (
    .clk         (clk),
    .rst_n       (rst_n),
    .prio_i      (prio_i),
    .pend_i      (pend),
    .clr_en_i    (clr_en),
    .set_i       (take),
    .set_idx_i   (pick_idx),
    .grant_eff_o (grant_eff),
    .grant_o     (grant_q)
  );

  sched_pick_arb #(.NCH(NCH), .IDXW(IDXW)) i_arb (
    .prio_i     (prio_i),
    .pend_i     (pend),
    .grant_i    (grant_eff),
    .pick_vld_o (pick_vld),
    .pick_idx_o (pick_idx)
  );

  logic            start_d;
  logic [IDXW-1:0] chan_d;

  always_comb begin
    start_d = take;
    chan_d  = chan_q;
    if (take) chan_d = pick_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      chan_q  <= '0;
      end_q   <= 1'b0;
    end else begin
      start_q <= start_d;
      chan_q  <= chan_d;
      end_q   <= thread_end_i;
    end
  end

  assign start_o = start_q;
  assign chan_o  = chan_q;

  // R8
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o);

  // R8
  start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle_i && !end_q) |=> !start_o);

  // R4
  grant_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> grant_q[chan_o]);
endmodule

// File: tb/test_svc_sched.sv
module test_svc_sched;
  localparam int NCH  = 8;
  localparam int IDXW = 3;

  logic                clk = 1'b0;
  logic                rst_n;
  logic [2*NCH-1:0]    prio;
  logic [NCH-1:0]      req;
  logic                tend;
  logic                idle;
  logic                start_o;
  logic [IDXW-1:0]     chan_o;

  always #2 clk = ~clk;

  svc_sched #(.NCH(NCH), .IDXW(IDXW)) i_svc_sched (
    .clk          (clk),
    .rst_n        (rst_n),
    .prio_i       (prio),
    .req_i        (req),
    .thread_end_i (tend),
    .idle_i       (idle),
    .start_o      (start_o),
    .chan_o       (chan_o)
  );

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  // reference state
  logic [NCH-1:0] m_pend, m_grant;
  logic           m_start, m_end;
  int             m_chan;

  // engine model
  bit eng_busy;
  int eng_left;

  // served log
  int seq [0:255];
  int seq_n;
  int served [0:NCH-1];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int lv_of(input int c);
    return int'(prio[2*c +: 2]);
  endfunction

  task automatic model_step();
    bit sel, clr, found, dn;
    int idx;
    logic [NCH-1:0] g;
    sel = !m_start && (idle || m_end);
    clr = tend || sel;
    g = m_grant;
    found = 0;
    idx = 0;
    if (clr) begin
      for (int lv = 1; lv < 4; lv++) begin
        dn = 1;
        for (int c = 0; c < NCH; c++)
          if (lv_of(c) == lv && m_pend[c] && !g[c]) dn = 0;
        if (dn)
          for (int c = 0; c < NCH; c++)
            if (lv_of(c) == lv) g[c] = 1'b0;
      end
      for (int c = 0; c < NCH; c++)
        if (lv_of(c) == 0) g[c] = 1'b0;
    end
    for (int lv = 3; lv >= 1; lv--)
      for (int c = 0; c < NCH; c++)
        if (!found && lv_of(c) == lv && m_pend[c] && !g[c]) begin
          found = 1;
          idx = c;
        end
    m_start = sel && found;
    if (m_start) begin
      g[idx] = 1'b1;
      m_pend[idx] = 1'b0;
      m_chan = idx;
    end
    m_pend  = m_pend | req;
    m_grant = g;
    m_end   = tend;
  endtask

  // one clock: compare at posedge+1, then advance engine and clear pulses
  task automatic cycle();
    bit tn;
    @(posedge clk);
    #1;
    model_step();
    chk(start_o == m_start, "R8 start strobe", int'(start_o), int'(m_start));
    if (m_start) begin
      chk(int'(chan_o) == m_chan, "R2 R3 R4 chosen channel", int'(chan_o), m_chan);
      if (seq_n < 256) seq[seq_n] = m_chan;
      seq_n++;
      served[m_chan]++;
    end
    tn = 0;
    if (eng_busy) begin
      if (eng_left == 0) begin
        tn = 1;
        eng_busy = 0;
      end else eng_left--;
    end
    if (start_o) begin
      eng_busy = 1;
      eng_left = $urandom_range(0, 3);
    end
    tend = tn;
    idle = !eng_busy && !tn;
    req  = '0;
  endtask

  task automatic set_prio(input int c, input int lv);
    prio[2*c +: 2] = 2'(lv);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic clear_log();
    seq_n = 0;
    for (int c = 0; c < NCH; c++) served[c] = 0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 0; prio = '0; req = '0; tend = 0; idle = 1;
    m_pend = '0; m_grant = '0; m_start = 0; m_end = 0; m_chan = 0;
    eng_busy = 0; eng_left = 0;
    clear_log();
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(start_o == 1'b0, "R1 reset start", int'(start_o), 0);
    chk(chan_o == '0, "R1 reset chan", int'(chan_o), 0);
    rst_n = 1;

    // R1 R6: all disabled, requests latched but never served
    req = 8'hFF;
    run(10);
    chk(seq_n == 0, "R1 no start while disabled", seq_n, 0);

    // R6: enable channel 0 low -> its old request is served
    set_prio(0, 1);
    run(8);
    chk(served[0] == 1, "R6 served after enable", served[0], 1);
    set_prio(0, 0);
    run(4);
    // drain remaining latched requests with all low
    for (int c = 0; c < NCH; c++) set_prio(c, 1);
    run(40);
    for (int c = 0; c < NCH; c++) set_prio(c, 0);
    run(4);

    // R2 R3: ch5 low, ch2 high, ch6 high
    clear_log();
    set_prio(5, 1); set_prio(2, 3); set_prio(6, 3);
    idle = 0;
    req = 8'b0110_0100;
    cycle();
    idle = !eng_busy && !tend;
    run(20);
    chk(seq_n == 3, "R2 three starts", seq_n, 3);
    chk(seq[0] == 2, "R3 first high lowest idx", seq[0], 2);
    chk(seq[1] == 6, "R3 second high", seq[1], 6);
    chk(seq[2] == 5, "R2 low after high", seq[2], 5);

    // R4 R5: ch1, ch3 high; ch1 re-requests constantly
    clear_log();
    set_prio(1, 3); set_prio(3, 3); set_prio(5, 0); set_prio(2, 0); set_prio(6, 0);
    run(4);
    clear_log();
    for (int i = 0; i < 30; i++) begin
      req[1] = 1'b1;
      if (i == 0) req[3] = 1'b1;
      cycle();
    end
    chk(seq[0] == 1, "R4 ch1 first", seq[0], 1);
    chk(seq[1] == 3, "R4 ch3 before ch1 again", seq[1], 3);
    chk(served[1] >= 2, "R5 ch1 served after clear", served[1], 2);
    for (int c = 0; c < NCH; c++) set_prio(c, 0);
    run(12);

    // R7: second request in the very clock ch4 is selected
    set_prio(4, 3);
    run(8);
    clear_log();
    idle = 1;
    req[4] = 1'b1;
    cycle();          // request latched at this edge
    req[4] = 1'b1;    // selection clock: new request collides with clear
    cycle();
    run(30);
    chk(served[4] == 2, "R7 collision request kept", served[4], 2);
    set_prio(4, 0);
    run(4);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 15) == 0)
        set_prio($urandom_range(0, NCH - 1), $urandom_range(0, 3));
      for (int c = 0; c < NCH; c++)
        if ($urandom_range(0, 9) == 0) req[c] = 1'b1;
      cycle();
    end
    chk(1'b1, "R5 random done", 0, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule